// File: doc/BRIEF.md
# Soft-Decision Branch Metric Unit

This block turns pairs of 3-bit soft samples from a rate-1/2 convolutional code into the branch metrics a Viterbi add-compare-select array uses. Every accepted step gives four radix-2 metrics, one for each possible expected code-symbol pair. Each metric is the Manhattan distance between the received pair and the ideal levels for that pair. The ideal level is 0 for a code bit of 0 and 7 for a code bit of 1.

Consecutive accepted steps are grouped two at a time. The first step of a group is kept in a holding register. When the second step arrives, the block emits sixteen radix-4 metrics. Each one is the sum of a first-step metric and a second-step metric, so a radix-4 decoder can advance two trellis stages per update. Generator polynomials and trellis wiring belong to the next stage and are not part of this block.

Top module: `soft_bm_unit`

## Requirements
- R1: Radix-2 metric index s (0..3) has expected bit s[1] for sample A and expected bit s[0] for sample B. Its value is |A − LA| + |B − LB|, where L is 0 for an expected bit of 0 and 7 for an expected bit of 1. Metric s sits in bits [4s+3:4s] of `r2_metrics`.
- R2: Radix-2 metrics are 4 bits wide and reach at most 14. For any input, metric 0 plus metric 3 equals 14, and metric 1 plus metric 2 equals 14.
- R3: `r2_valid` is high in exactly the cycle after each cycle with `in_valid` high. `r2_metrics` then shows the metrics of that step.
- R4: Accepted steps are paired in order, starting with the first step after reset. `r4_valid` pulses one cycle after the second step of each pair, in the same cycle as that step's `r2_valid`. It never pulses for a first step.
- R5: Radix-4 metric index p·4+q, in bits [5i+4:5i] of `r4_metrics`, equals first-step radix-2 metric p plus second-step radix-2 metric q, 5 bits wide.
- R6: A cycle with `in_valid` low has no effect: the next cycle shows both valids low and both metric vectors unchanged, and the pairing position does not move.
- R7: Reset clears both valids and both metric vectors, and restarts the pairing, so the next accepted step is a first step.
- R8: Steps may arrive on back-to-back cycles with no loss. A radix-4 pulse then appears every second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample pair present this cycle |
| samp_a | input | 3 | First soft sample of the step |
| samp_b | input | 3 | Second soft sample of the step |
| r2_valid | output | 1 | Radix-2 metric vector updated |
| r2_metrics | output | 16 | Four 4-bit radix-2 metrics |
| r4_valid | output | 1 | Radix-4 metric vector updated |
| r4_metrics | output | 80 | Sixteen 5-bit radix-4 metrics |

## Verification
The radix-2 update for a second step and the radix-4 emission happen in the same cycle. The combined sums must use the held first step and not be disturbed by the radix-2 register loading the new step. The bench drives long back-to-back runs and pairs separated by idle gaps. In each output cycle it compares both vectors against metrics it computes itself from the samples of the two steps. Reset in the middle of a pair checks that the pairing restarts.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  // Number of expected symbol pairs per radix-2 step (rate 1/2 -> 2 bits)
  localparam int SYM_BITS = 2;
  localparam int NUM_SYM  = 1 << SYM_BITS;
  localparam int NUM_PAIR = NUM_SYM * NUM_SYM;

  typedef enum logic {
    PH_FIRST  = 1'b0,
    PH_SECOND = 1'b1
  } pair_phase_e;
endpackage

// File: rtl/sbm_r2_calc.sv
module sbm_r2_calc
  import sbm_pkg::*;
#(
  parameter int SAMP_W = 3,
  parameter int R2_W   = 4
) (
  input  logic [SAMP_W-1:0]       samp_a,
  input  logic [SAMP_W-1:0]       samp_b,
  output logic [NUM_SYM*R2_W-1:0] metrics
);
  localparam logic [SAMP_W-1:0] TOP_LVL = {SAMP_W{1'b1}};

  // Distance to the ideal level: the level is either 0 or full scale,
  // so the absolute value needs no sign handling.
  function automatic logic [R2_W-1:0] lvl_dist(input logic [SAMP_W-1:0] g,
                                               input logic bit_one);
    logic [SAMP_W-1:0] d;
    d = bit_one ? (TOP_LVL - g) : g;
    return R2_W'(d);
  endfunction

  for (genvar s = 0; s < NUM_SYM; s++) begin : g_sym
    localparam logic [SYM_BITS-1:0] SV = SYM_BITS'(s);
    assign metrics[s*R2_W +: R2_W] = lvl_dist(samp_a, SV[1]) + lvl_dist(samp_b, SV[0]);
  end
endmodule

// File: rtl/sbm_pair_ctrl.sv
module sbm_pair_ctrl
  import sbm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic take_first,
  output logic take_second
);
  pair_phase_e phase_q;

  assign take_first  = in_valid && (phase_q == PH_FIRST);
  assign take_second = in_valid && (phase_q == PH_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FIRST;
    end else if (take_first) begin
      phase_q <= PH_SECOND;
    end else if (take_second) begin
      phase_q <= PH_FIRST;
    end
  end
endmodule

// File: rtl/sbm_r4_combine.sv
module sbm_r4_combine
  import sbm_pkg::*;
#(
  parameter int R2_W = 4,
  parameter int R4_W = 5
) (
  input  logic [NUM_SYM*R2_W-1:0]  first_m,
  input  logic [NUM_SYM*R2_W-1:0]  second_m,
  output logic [NUM_PAIR*R4_W-1:0] sums
);
  function automatic logic [R4_W-1:0] join_sum(input logic [R2_W-1:0] a,
                                               input logic [R2_W-1:0] b);
    return R4_W'(a) + R4_W'(b);
  endfunction

  for (genvar p = 0; p < NUM_SYM; p++) begin : g_p
    for (genvar q = 0; q < NUM_SYM; q++) begin : g_q
      assign sums[(p*NUM_SYM+q)*R4_W +: R4_W] =
        join_sum(first_m[p*R2_W +: R2_W], second_m[q*R2_W +: R2_W]);
    end
  end
endmodule

// File: rtl/soft_bm_unit.sv
module soft_bm_unit
  import sbm_pkg::*;
#(
  parameter int SAMP_W = 3,
  parameter int R2_W   = $clog2(2 * ((1 << SAMP_W) - 1) + 1),
  parameter int R4_W   = $clog2(4 * ((1 << SAMP_W) - 1) + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [SAMP_W-1:0]        samp_a,
  input  logic [SAMP_W-1:0]        samp_b,
  output logic                     r2_valid,
  output logic [NUM_SYM*R2_W-1:0]  r2_metrics,
  output logic                     r4_valid,
  output logic [NUM_PAIR*R4_W-1:0] r4_metrics
);
  logic [NUM_SYM*R2_W-1:0]  r2_now;
  logic [NUM_SYM*R2_W-1:0]  first_stage_q;
  logic [NUM_PAIR*R4_W-1:0] r4_now;
  logic                     take_first;
  logic                     take_second;

  sbm_r2_calc #(.SAMP_W(SAMP_W), .R2_W(R2_W)) u_r2 (
    .samp_a (samp_a),
    .samp_b (samp_b),
    .metrics(r2_now)
  );

  sbm_pair_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .take_first (take_first),
    .take_second(take_second)
  );

  sbm_r4_combine #(.R2_W(R2_W), .R4_W(R4_W)) u_r4 (
    .first_m (first_stage_q),
    .second_m(r2_now),
    .sums    (r4_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r2_valid      <= 1'b0;
      r2_metrics    <= '0;
      r4_valid      <= 1'b0;
      r4_metrics    <= '0;
      first_stage_q <= '0;
    end else begin
      r2_valid <= in_valid;
      r4_valid <= take_second;
      if (in_valid)    r2_metrics    <= r2_now;
      if (take_first)  first_stage_q <= r2_now;
      if (take_second) r4_metrics    <= r4_now;
    end
  end
endmodule

// File: rtl/soft_bm_unit_chk.sv
module soft_bm_unit_chk
  import sbm_pkg::*;
#(
  parameter int SAMP_W = 3,
  parameter int R2_W   = 4,
  parameter int R4_W   = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     r2_valid,
  input logic [NUM_SYM*R2_W-1:0]  r2_metrics,
  input logic                     r4_valid,
  input logic [NUM_PAIR*R4_W-1:0] r4_metrics,
  input logic [NUM_SYM*R2_W-1:0]  first_hold
);
  localparam int FULL = 2 * ((1 << SAMP_W) - 1);

  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> r2_valid);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !r2_valid);
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(r2_metrics) && $stable(r4_metrics) && !r4_valid));
  a_r4_with_r2: assert property (@(posedge clk) disable iff (!rst_n)
    r4_valid |-> r2_valid);
  a_r4_not_twice: assert property (@(posedge clk) disable iff (!rst_n)
    r4_valid |=> !r4_valid);
  a_r2_complement: assert property (@(posedge clk) disable iff (!rst_n)
    r2_valid |-> ((32'(r2_metrics[0 +: R2_W]) + 32'(r2_metrics[3*R2_W +: R2_W]) == FULL) &&
                  (32'(r2_metrics[R2_W +: R2_W]) + 32'(r2_metrics[2*R2_W +: R2_W]) == FULL)));
  a_r7_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!r2_valid && !r4_valid));

  for (genvar p = 0; p < NUM_SYM; p++) begin : g_p
    for (genvar q = 0; q < NUM_SYM; q++) begin : g_q
      a_r5_sum: assert property (@(posedge clk) disable iff (!rst_n)
        r4_valid |-> (32'(r4_metrics[(p*NUM_SYM+q)*R4_W +: R4_W]) ==
                      32'(first_hold[p*R2_W +: R2_W]) + 32'(r2_metrics[q*R2_W +: R2_W])));
    end
  end
endmodule

bind soft_bm_unit soft_bm_unit_chk #(.SAMP_W(SAMP_W), .R2_W(R2_W), .R4_W(R4_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .r2_valid  (r2_valid),
  .r2_metrics(r2_metrics),
  .r4_valid  (r4_valid),
  .r4_metrics(r4_metrics),
  .first_hold(first_stage_q)
);

// File: tb/soft_bm_unit_test.sv
module soft_bm_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  samp_a = '0;
  logic [2:0]  samp_b = '0;
  logic        r2_valid;
  logic [15:0] r2_metrics;
  logic        r4_valid;
  logic [79:0] r4_metrics;

  int checks = 0;
  int errors = 0;
  logic        exp_second = 1'b0;
  logic [15:0] exp_first = '0;

  always #4 clk = ~clk;

  soft_bm_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .samp_a(samp_a), .samp_b(samp_b),
    .r2_valid(r2_valid), .r2_metrics(r2_metrics),
    .r4_valid(r4_valid), .r4_metrics(r4_metrics)
  );

  // Stimulus table: {A, B} per step
  localparam logic [5:0] VEC [12] = '{
    {3'd0, 3'd0}, {3'd7, 3'd7}, {3'd3, 3'd4}, {3'd1, 3'd6},
    {3'd5, 3'd2}, {3'd7, 3'd0}, {3'd0, 3'd7}, {3'd4, 3'd4},
    {3'd6, 3'd1}, {3'd2, 3'd5}, {3'd3, 3'd3}, {3'd7, 3'd1}
  };

  function automatic logic [15:0] model_r2(input logic [2:0] a, input logic [2:0] b);
    logic [15:0] v;
    for (int s = 0; s < 4; s++) begin
      int la, lb, da, db;
      la = (s >= 2) ? 7 : 0;
      lb = (s % 2 == 1) ? 7 : 0;
      da = int'(a) - la; if (da < 0) da = -da;
      db = int'(b) - lb; if (db < 0) db = -db;
      v[4*s +: 4] = 4'(da + db);
    end
    return v;
  endfunction

  function automatic logic [79:0] model_r4(input logic [15:0] f, input logic [15:0] s2);
    logic [79:0] v;
    for (int p = 0; p < 4; p++)
      for (int q = 0; q < 4; q++)
        v[5*(4*p+q) +: 5] = 5'(int'(f[4*p +: 4]) + int'(s2[4*q +: 4]));
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle, then check outputs just after the sampling edge.
  task automatic step(input logic v, input logic [2:0] a, input logic [2:0] b);
    logic [15:0] prev_r2;
    logic [79:0] prev_r4;
    logic [15:0] e2;
    logic        e4;
    @(negedge clk);
    prev_r2 = r2_metrics;
    prev_r4 = r4_metrics;
    in_valid = v; samp_a = a; samp_b = b;
    e2 = model_r2(a, b);
    @(posedge clk); #1;
    in_valid = 1'b0;
    if (v) begin
      check(r2_valid === 1'b1, "R3 r2_valid", 80'(r2_valid), 80'(1));
      check(r2_metrics === e2, "R1 r2_metrics", 80'(r2_metrics), 80'(e2));
      check((32'(r2_metrics[3:0]) + 32'(r2_metrics[15:12]) == 14), "R2 complement",
            80'(r2_metrics), 80'(e2));
      e4 = exp_second;
      check(r4_valid === e4, "R4 r4_valid", 80'(r4_valid), 80'(e4));
      if (e4)
        check(r4_metrics === model_r4(exp_first, e2), "R5 r4_metrics",
              r4_metrics, model_r4(exp_first, e2));
      else
        exp_first = e2;
      exp_second = ~exp_second;
    end else begin
      check(r2_valid === 1'b0 && r4_valid === 1'b0, "R6 idle valids",
            80'({r2_valid, r4_valid}), 80'(0));
      check(r2_metrics === prev_r2 && r4_metrics === prev_r4, "R6 idle hold",
            {r2_metrics, r4_metrics[63:0]}, {prev_r2, prev_r4[63:0]});
    end
  endtask

  initial begin
    #1600000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R7: reset state
    check(r2_valid === 1'b0 && r4_valid === 1'b0, "R7 reset valids",
          80'({r2_valid, r4_valid}), 80'(0));
    check(r2_metrics === '0 && r4_metrics === '0, "R7 reset metrics",
          {r2_metrics, r4_metrics[63:0]}, 80'(0));
    @(negedge clk) rst_n = 1'b1;

    // R8: back-to-back walk of the table
    for (int i = 0; i < 12; i++) step(1'b1, VEC[i][5:3], VEC[i][2:0]);

    // R6: idle gaps inside a pair do not move the pairing
    step(1'b1, 3'd2, 3'd6);
    step(1'b0, 3'd5, 3'd5);
    step(1'b0, 3'd1, 3'd0);
    step(1'b1, 3'd7, 3'd3);
    step(1'b0, 3'd0, 3'd0);

    // R2: extreme values
    step(1'b1, 3'd7, 3'd7);
    step(1'b1, 3'd0, 3'd0);

    // R7: reset in the middle of a pair restarts the pairing
    step(1'b1, 3'd4, 3'd1);
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk); #1;
    check(r2_valid === 1'b0 && r4_valid === 1'b0 && r2_metrics === '0, "R7 mid-pair reset",
          80'({r2_valid, r4_valid, r2_metrics}), 80'(0));
    @(negedge clk) rst_n = 1'b1;
    exp_second = 1'b0;
    step(1'b1, 3'd6, 3'd2);   // must be a first step: no r4 pulse
    step(1'b1, 3'd1, 3'd5);   // completes the pair

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule